// File: doc/BRIEF.md
# Sequential Multiply-Accumulate FIR Filter

This block is a finite impulse response filter that shares one multiplier and one accumulator across all of its taps. Each accepted input sample is written into a circular history of the most recent `TAPS` samples. The block then walks a tap index from 0 to `TAPS-1`, one step per clock. Each step reads one coefficient from a constant, registered-output coefficient ROM and one past sample from the history, and adds their product into the accumulator. One output sample therefore costs `TAPS` multiply-accumulate cycles plus two pipeline cycles, in place of `TAPS` parallel multipliers.

The upstream side offers a sample with `smp_valid`. It is taken only while `smp_ready` is high, and `smp_ready` stays low for the whole computation. The downstream side sees the full-precision sum on `res_data` together with a one-cycle `res_valid` pulse. The result holds until the next pulse.

Top module: `mac_fir`

## Requirements
- R1: After reset `smp_ready` is 1, `res_valid` is 0, `res_data` is 0, and every history entry is 0.
- R2: A sample is accepted on a rising edge where `smp_valid` and `smp_ready` are both 1. `smp_ready` is 0 in the cycle that follows.
- R3: While `smp_ready` is 0, `smp_valid` and `smp_data` have no effect. Samples offered then are never stored and never reach any later result.
- R4: Each result equals the sum over k = 0..TAPS-1 of c_k times x(n-k). Here x(n) is the newest accepted sample and x(n-k) is the sample accepted k acceptances earlier. Positions not yet filled since reset count as 0. All operands are two's complement signed.
- R5: The coefficients are fixed constants: c_k = ((k*7919 + 1234) mod 2^COEF_W) - 2^(COEF_W-1), with COEF_W = 18 by default.
- R6: `res_valid` is high for exactly one cycle. It first reads 1 after the (TAPS+2)-th rising edge counted from the accepting edge. Exactly TAPS products are added for each result.
- R7: `smp_ready` returns to 1 in the same cycle that `res_valid` is 1, and a sample may be accepted on the next edge.
- R8: `res_data` is DATA_W + COEF_W + ceil(log2 TAPS) bits wide and signed. No combination of extreme inputs overflows it.
- R9: `res_data` holds its value between `res_valid` pulses.
- R10: The history is circular. After more than TAPS acceptances, the oldest sample drops out of the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Input sample offered |
| smp_data | input | DATA_W | Signed input sample |
| smp_ready | output | 1 | Filter idle, sample can be taken |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DATA_W+COEF_W+clog2(TAPS) | Signed filter result |

## Verification
The bench builds the filter with TAPS = 5, DATA_W = 12 and COEF_W = 18. A tap count that is not a power of two makes the circular read pointer wrap through its explicit modulo path rather than by natural overflow. With only five taps, the history fills and overflows within a few samples, so the drop-out of old samples is exercised many times. Twelve-bit samples at -2048 and +2047 set against 18-bit coefficients drive the 33-bit accumulator near its extremes.

// File: rtl/mac_fir_pkg.sv
package mac_fir_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } fir_state_t;

  // Accumulator width that cannot overflow for n products.
  function automatic int acc_bits(input int dw, input int cw, input int n);
    return dw + cw + ((n > 1) ? $clog2(n) : 0);
  endfunction

  // Address width for an n-deep store.
  function automatic int addr_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Circular position k steps behind head in a ring of n entries.
  function automatic int ring_back(input int head, input int k, input int n);
    return (head >= k) ? (head - k) : (head + n - k);
  endfunction

  // Circular successor of p in a ring of n entries.
  function automatic int ring_next(input int p, input int n);
    return (p == n - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/mac_fir_coef_rom.sv
module mac_fir_coef_rom #(
  parameter int COEF_W = 18,
  parameter int TAPS   = 8,
  parameter int IW     = 3
) (
  input  logic                     clk,
  input  logic                     rd_en,
  input  logic [IW-1:0]            rd_idx,
  output logic signed [COEF_W-1:0] coef_q
);

  // c_k = ((k*7919 + 1234) mod 2^W) - 2^(W-1): the truncated sum
  // with its top bit flipped, read as signed.
  function automatic logic signed [COEF_W-1:0] coef_at(input logic [IW-1:0] k);
    logic [COEF_W-1:0] v;
    v = COEF_W'(k) * COEF_W'(7919) + COEF_W'(1234);
    return {~v[COEF_W-1], v[COEF_W-2:0]};
  endfunction

  logic signed [COEF_W-1:0] coef_d;

  always_comb coef_d = coef_at(rd_idx);

  // Registered read: the value appears one edge after the address.
  always_ff @(posedge clk) begin
    if (rd_en) coef_q <= coef_d;
  end

endmodule

// File: rtl/mac_fir_hist.sv
module mac_fir_hist
  import mac_fir_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAPS   = 8,
  parameter int AW     = 3,
  parameter int IW     = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic signed [DATA_W-1:0] wr_data,
  input  logic                     rd_en,
  input  logic [IW-1:0]            rd_back,
  output logic signed [DATA_W-1:0] rd_q,
  output logic [AW-1:0]            head
);

  logic signed [DATA_W-1:0] ring [TAPS];
  logic [AW-1:0] head_nxt;
  logic [AW-1:0] rd_addr;

  always_comb begin
    head_nxt = AW'(ring_next(int'(head), TAPS));
    rd_addr  = AW'(ring_back(int'(head), int'(rd_back), TAPS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
    end else if (wr_en) begin
      head <= head_nxt;
    end
  end

  for (genvar e = 0; e < TAPS; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ring[e] <= '0;
      end else if (wr_en && head_nxt == AW'(e)) begin
        ring[e] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= ring[rd_addr];
    end
  end

endmodule

// File: rtl/mac_fir_seq.sv
module mac_fir_seq
  import mac_fir_pkg::*;
#(
  parameter int TAPS = 8,
  parameter int IW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          acc_done,
  output logic          ready,
  output logic          accept,
  output logic          issue,
  output logic          issue_first,
  output logic          issue_last,
  output logic [IW-1:0] idx
);

  fir_state_t state;

  always_comb begin
    ready       = (state == ST_IDLE);
    accept      = ready && in_valid;
    issue       = (state == ST_RUN);
    issue_first = issue && (idx == '0);
    issue_last  = issue && (idx == IW'(TAPS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          idx <= '0;
          if (accept) state <= ST_RUN;
        end
        ST_RUN: begin
          if (issue_last) begin
            state <= ST_DRAIN;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (acc_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mac_fir_mac.sv
module mac_fir_mac #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 18,
  parameter int ACC_W  = 37
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prod_vld,
  input  logic                     prod_first,
  input  logic                     prod_last,
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [ACC_W-1:0]  prod_ext,
  output logic signed [ACC_W-1:0]  acc,
  output logic                     acc_done,
  output logic signed [ACC_W-1:0]  res,
  output logic                     res_vld
);

  localparam int PW = DATA_W + COEF_W;

  logic signed [PW-1:0] prod;

  always_comb begin
    prod     = sample * coef;
    prod_ext = ACC_W'(prod);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      acc_done <= 1'b0;
      res      <= '0;
      res_vld  <= 1'b0;
    end else begin
      if (prod_vld) acc <= prod_first ? prod_ext : acc + prod_ext;
      acc_done <= prod_vld && prod_last;
      res_vld  <= acc_done;
      if (acc_done) res <= acc;
    end
  end

endmodule

// File: rtl/mac_fir.sv
module mac_fir
  import mac_fir_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 18,
  parameter int TAPS   = 8,
  localparam int ACC_W = acc_bits(DATA_W, COEF_W, TAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] smp_data,
  output logic                     smp_ready,
  output logic                     res_valid,
  output logic signed [ACC_W-1:0]  res_data
);

  localparam int AW = addr_bits(TAPS);
  localparam int IW = addr_bits(TAPS);

  // Named internal events for the checker.
  logic          evt_accept;
  logic          evt_issue;
  logic          evt_issue_first;
  logic          evt_issue_last;
  logic          evt_mac;
  logic          evt_mac_first;
  logic          evt_mac_last;
  logic          acc_done;
  logic [IW-1:0] tap_idx;
  logic [AW-1:0] head;

  logic signed [DATA_W-1:0] hist_q;
  logic signed [COEF_W-1:0] coef_q;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc;

  mac_fir_seq #(.TAPS(TAPS), .IW(IW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (smp_valid),
    .acc_done    (acc_done),
    .ready       (smp_ready),
    .accept      (evt_accept),
    .issue       (evt_issue),
    .issue_first (evt_issue_first),
    .issue_last  (evt_issue_last),
    .idx         (tap_idx)
  );

  mac_fir_hist #(.DATA_W(DATA_W), .TAPS(TAPS), .AW(AW), .IW(IW)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (evt_accept),
    .wr_data (smp_data),
    .rd_en   (evt_issue),
    .rd_back (tap_idx),
    .rd_q    (hist_q),
    .head    (head)
  );

  mac_fir_coef_rom #(.COEF_W(COEF_W), .TAPS(TAPS), .IW(IW)) u_rom (
    .clk    (clk),
    .rd_en  (evt_issue),
    .rd_idx (tap_idx),
    .coef_q (coef_q)
  );

  // Align control with the one-cycle read latency.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_mac       <= 1'b0;
      evt_mac_first <= 1'b0;
      evt_mac_last  <= 1'b0;
    end else begin
      evt_mac       <= evt_issue;
      evt_mac_first <= evt_issue_first;
      evt_mac_last  <= evt_issue_last;
    end
  end

  mac_fir_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk        (clk),
    .rst_n      (rst_n),
    .prod_vld   (evt_mac),
    .prod_first (evt_mac_first),
    .prod_last  (evt_mac_last),
    .sample     (hist_q),
    .coef       (coef_q),
    .prod_ext   (prod_ext),
    .acc        (acc),
    .acc_done   (acc_done),
    .res        (res_data),
    .res_vld    (res_valid)
  );

endmodule

// File: rtl/mac_fir_chk.sv
module mac_fir_chk #(
  parameter int TAPS  = 8,
  parameter int ACC_W = 37,
  parameter int AW    = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_valid,
  input logic                    smp_ready,
  input logic                    res_valid,
  input logic signed [ACC_W-1:0] res_data,
  input logic                    evt_accept,
  input logic                    evt_mac,
  input logic                    evt_mac_first,
  input logic signed [ACC_W-1:0] prod_ext,
  input logic signed [ACC_W-1:0] acc,
  input logic [AW-1:0]           head
);

  int mac_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          mac_cnt <= 0;
    else if (evt_accept) mac_cnt <= 0;
    else if (evt_mac)    mac_cnt <= mac_cnt + 1;
  end

  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> !smp_ready);

  assert_busy_ignores_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> $stable(head));

  assert_first_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_mac_first |=> (acc == $past(prod_ext)));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_tap_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (mac_cnt == TAPS));

  assert_ready_with_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> smp_ready);

  assert_result_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_data));

endmodule

bind mac_fir mac_fir_chk #(.TAPS(TAPS), .ACC_W(ACC_W), .AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .smp_valid     (smp_valid),
  .smp_ready     (smp_ready),
  .res_valid     (res_valid),
  .res_data      (res_data),
  .evt_accept    (evt_accept),
  .evt_mac       (evt_mac),
  .evt_mac_first (evt_mac_first),
  .prod_ext      (prod_ext),
  .acc           (acc),
  .head          (head)
);

// File: tb/tb_mac_fir.sv
module tb_mac_fir;

  localparam int DW = 12;
  localparam int CW = 18;
  localparam int N  = 5;
  localparam int AW = DW + CW + $clog2(N);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 smp_valid = 1'b0;
  logic signed [DW-1:0] smp_data = '0;
  logic                 smp_ready;
  logic                 res_valid;
  logic signed [AW-1:0] res_data;

  int total = 0;
  int bad   = 0;
  longint hist [N];

  always #2.5 clk = ~clk;

  mac_fir #(.DATA_W(DW), .COEF_W(CW), .TAPS(N)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .smp_ready (smp_ready),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  function automatic longint coef(input int k);
    return ((longint'(k) * 7919 + 1234) % 262144) - 131072;
  endfunction

  function automatic longint model_sum();
    longint s = 0;
    for (int k = 0; k < N; k++) s += coef(k) * hist[k];
    return s;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Offer one sample, send junk while busy, and check the result.
  task automatic run_sample(input longint x, input bit junk);
    int cyc = 0;
    @(negedge clk);
    while (!smp_ready) @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = DW'(x);
    @(posedge clk);
    for (int k = N - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    @(negedge clk);
    check("R2 ready low after accept", longint'(smp_ready), 0);
    smp_valid = 1'b0;
    forever begin
      if (junk && cyc < N - 1) begin
        smp_valid = $urandom_range(0, 1) != 0;  // R3: ignored while busy
        smp_data  = DW'($urandom);
      end else begin
        smp_valid = 1'b0;
      end
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (res_valid || cyc > N + 6) break;
    end
    smp_valid = 1'b0;
    check("R6 latency", cyc, N + 2);
    check("R7 ready with result", longint'(smp_ready), 1);
    check("R4 R3 R10 result", longint'(res_data), model_sum());
    @(negedge clk);
    check("R6 single pulse", longint'(res_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint held;
    void'($urandom(32'd4242));
    for (int k = 0; k < N; k++) hist[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", longint'(smp_ready), 1);
    check("R1 valid", longint'(res_valid), 0);
    check("R1 data", longint'(res_data), 0);

    // R5: impulse reads each coefficient out in turn.
    run_sample(1, 1'b0);
    check("R5 c0", longint'(res_data), coef(0));
    for (int k = 1; k < N; k++) begin
      run_sample(0, 1'b0);
      check("R5 ck", longint'(res_data), coef(k));
    end
    // R10: impulse has dropped out of the history.
    run_sample(0, 1'b0);
    check("R10 oldest dropped", longint'(res_data), 0);

    // R9: result holds while idle.
    held = longint'(res_data);
    repeat (7) @(negedge clk);
    check("R9 hold", longint'(res_data), held);

    // R8: extremes.
    for (int i = 0; i < N + 1; i++) run_sample(-2048, 1'b1);
    for (int i = 0; i < N + 1; i++) run_sample(2047, 1'b1);
    for (int i = 0; i < N; i++) run_sample((i % 2 == 0) ? -2048 : 2047, 1'b0);
    check("R8 extreme", longint'(res_data), model_sum());

    // R3/R4/R10: random stream with junk offered while busy.
    for (int i = 0; i < 60; i++) begin
      run_sample(longint'($signed(DW'($urandom))), 1'b1);
    end

    // R7: back-to-back offer right when ready returns.
    run_sample(123, 1'b0);
    run_sample(-77, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule